// File: doc/BRIEF.md
# Instruction-Boundary Event Arbiter

This block decides which pending event a processor core services when an instruction completes. Five kinds of event compete. The first is a software event: an interrupt instruction, or an exception raised by the instruction that just finished, which carries its own vector. The second is a single-step trap. The third is a non-maskable interrupt (NMI). The fourth is a coprocessor error. The fifth is a maskable external interrupt, which carries a vector supplied from outside.

The core pulses a boundary strobe at the end of each instruction. On the next clock the block answers with one acknowledge pulse and the 8-bit vector of the winning event. If no event is eligible, it answers with nothing. The block also tracks the NMI mask. Once an NMI has been accepted, further NMIs are held back until the core reports that an interrupt-return instruction has executed.

The coprocessor error line is wired straight into the block and always resolves to vector 16. When a software event is taken while the trap flag is set, the block remembers a pending single-step. That step is then taken at the following boundary, so handlers entered by software are still stepped. External interrupts cannot pre-empt a pending step.

Top module: `event_arbiter`

## Requirements
- R1: After synchronous reset, `ack_o` is 0, `vec_o` is 0, `nmi_mask_o` is 0, and no step or NMI is pending.
- R2: Every clock edge where `bnd_i` is 1 and at least one event is eligible produces `ack_o`=1 for exactly the following cycle. If no event is eligible, or `bnd_i` is 0, `ack_o` stays 0.
- R3: Fixed priority applies at each boundary, highest first. The order is: software event (`sw_vec_i`), single-step (vector 1), NMI (vector 2), coprocessor error (vector 16), maskable interrupt (`intr_vec_i`). The single-step candidate is `tf_i` OR the internally pending step.
- R4: A software event taken while `tf_i`=1 leaves a step pending. The next boundary then delivers vector 1, even if `tf_i` has dropped and other requests are present.
- R5: A rising edge on `nmi_i` is latched as a pending NMI. That NMI is eligible at boundaries from the second clock edge after the rise, even if `nmi_i` has already returned low.
- R6: Taking an NMI sets `nmi_mask_o`, which stays 1 until an `iret_i` strobe. While the mask is 1, a pending NMI is not taken. It is taken at the first boundary after the edge that carries `iret_i`.
- R7: A coprocessor error is delivered on vector 16, independent of `ie_i` and `intr_vec_i`.
- R8: The maskable interrupt is eligible only when `ie_i`=1, and it is delivered on `intr_vec_i`.
- R9: Requests that lose arbitration stay pending. Level inputs remain eligible while they are held, and a latched NMI or step remains latched.
- R10: Each NMI edge is serviced at most once. The pending NMI clears when it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_i | input | 1 | Instruction boundary strobe |
| iret_i | input | 1 | Interrupt-return executed strobe |
| tf_i | input | 1 | Trap flag of the instruction that just completed |
| ie_i | input | 1 | Interrupt-enable flag |
| sw_req_i | input | 1 | Software interrupt or exception raised at this boundary |
| sw_vec_i | input | 8 | Vector of the software event |
| nmi_i | input | 1 | Non-maskable interrupt request (edge-sensitive) |
| fpu_err_i | input | 1 | Coprocessor error request (level) |
| intr_i | input | 1 | Maskable interrupt request (level) |
| intr_vec_i | input | 8 | Vector of the maskable interrupt |
| ack_o | output | 1 | One-cycle acknowledge of the chosen event |
| vec_o | output | 8 | Vector of the last acknowledged event |
| nmi_mask_o | output | 1 | NMI mask state |

## Verification
A decision made at the boundary edge appears on `ack_o` and `vec_o` one cycle later, and the mask update appears on `nmi_mask_o` in the same cycle. An NMI rise needs two clock edges before it can win, and an `iret_i` strobe unmasks only boundaries that come after its own edge. The bench drives inputs on falling edges and samples on the falling edge that follows each boundary edge. It sweeps all 64 combinations of software, trap, NMI, coprocessor, maskable and enable inputs. Each combination gets a follow-up boundary with all requests removed, which exposes any latched step or NMI that was left behind.

// File: rtl/evarb_pkg.sv
package evarb_pkg;

    localparam int VEC_W   = 8;
    localparam int NUM_SRC = 5;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_SW,
        SRC_STEP,
        SRC_NMI,
        SRC_FPU,
        SRC_INTR
    } src_e;

    typedef struct packed {
        src_e src;
        vec_t vec;
    } pick_t;

    localparam vec_t STEP_VEC = vec_t'(1);
    localparam vec_t NMI_VEC  = vec_t'(2);
    localparam vec_t FPU_VEC  = vec_t'(16);

    // Candidate slot to source kind; slot 0 has the highest priority.
    function automatic src_e slot_src(input int slot);
        case (slot)
            0:       return SRC_SW;
            1:       return SRC_STEP;
            2:       return SRC_NMI;
            3:       return SRC_FPU;
            4:       return SRC_INTR;
            default: return SRC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/evarb_select.sv
module evarb_select
    import evarb_pkg::*;
(
    input  logic [NUM_SRC-1:0]            req_i,
    input  logic [NUM_SRC-1:0][VEC_W-1:0] vec_i,
    output pick_t                         pick_o,
    output logic                          any_o
);

    logic hit;

    always_comb begin
        pick_o = '{src: SRC_NONE, vec: '0};
        hit    = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (req_i[s] && !hit) begin
                pick_o.src = slot_src(s);
                pick_o.vec = vec_i[s];
                hit        = 1'b1;
            end
        end
        any_o = hit;
    end

endmodule

// File: rtl/evarb_nmi_ctl.sv
module evarb_nmi_ctl (
    input  logic clk,
    input  logic rst,
    input  logic nmi_i,
    input  logic take_i,
    input  logic iret_i,
    output logic pend_o,
    output logic mask_o
);

    logic nmi_q;
    logic rise;

    assign rise = nmi_i && !nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q  <= 1'b0;
            pend_o <= 1'b0;
            mask_o <= 1'b0;
        end else begin
            nmi_q <= nmi_i;
            if (rise)
                pend_o <= 1'b1;
            else if (take_i)
                pend_o <= 1'b0;
            if (take_i)
                mask_o <= 1'b1;
            else if (iret_i)
                mask_o <= 1'b0;
        end
    end

    AST_NMI_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
        rise |=> pend_o);                                        // R5
    AST_NMI_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        take_i |=> mask_o);                                      // R6
    AST_NMI_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mask_o && !iret_i) |=> mask_o);                         // R6
    AST_NMI_NOT_MASKED: assert property (@(posedge clk) disable iff (rst)
        take_i |-> (!mask_o && pend_o));                         // R6
    AST_NMI_ONCE: assert property (@(posedge clk) disable iff (rst)
        (take_i && !rise) |=> !pend_o);                          // R10

endmodule

// File: rtl/evarb_step_ctl.sv
module evarb_step_ctl (
    input  logic clk,
    input  logic rst,
    input  logic tf_i,
    input  logic sw_take_i,
    input  logic step_take_i,
    output logic pend_o
);

    always_ff @(posedge clk) begin
        if (rst)
            pend_o <= 1'b0;
        else if (sw_take_i && tf_i)
            pend_o <= 1'b1;
        else if (step_take_i)
            pend_o <= 1'b0;
    end

    AST_STEP_ARM: assert property (@(posedge clk) disable iff (rst)
        (sw_take_i && tf_i) |=> pend_o);                         // R4
    AST_STEP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !step_take_i) |=> pend_o);                    // R9

endmodule

// File: rtl/event_arbiter.sv
module event_arbiter
    import evarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bnd_i,
    input  logic             iret_i,
    input  logic             tf_i,
    input  logic             ie_i,
    input  logic             sw_req_i,
    input  logic [VEC_W-1:0] sw_vec_i,
    input  logic             nmi_i,
    input  logic             fpu_err_i,
    input  logic             intr_i,
    input  logic [VEC_W-1:0] intr_vec_i,
    output logic             ack_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             nmi_mask_o
);

    logic                            nmi_pend;
    logic                            step_pend;
    logic                            nmi_ready;
    logic [NUM_SRC-1:0]              cand_req;
    logic [NUM_SRC-1:0][VEC_W-1:0]   cand_vec;
    pick_t                           pick;
    logic                            any;
    logic                            grant;
    logic                            take_nmi;
    logic                            take_sw;
    logic                            take_step;
    src_e                            src_q;

    assign nmi_ready = nmi_pend && !nmi_mask_o;

    always_comb begin
        cand_req[0] = sw_req_i;
        cand_req[1] = tf_i || step_pend;
        cand_req[2] = nmi_ready;
        cand_req[3] = fpu_err_i;
        cand_req[4] = intr_i && ie_i;
        cand_vec[0] = sw_vec_i;
        cand_vec[1] = STEP_VEC;
        cand_vec[2] = NMI_VEC;
        cand_vec[3] = FPU_VEC;
        cand_vec[4] = intr_vec_i;
    end

    evarb_select u_select (
        .req_i  (cand_req),
        .vec_i  (cand_vec),
        .pick_o (pick),
        .any_o  (any)
    );

    assign grant     = bnd_i && any;
    assign take_nmi  = grant && (pick.src == SRC_NMI);
    assign take_sw   = grant && (pick.src == SRC_SW);
    assign take_step = grant && (pick.src == SRC_STEP);

    evarb_nmi_ctl u_nmi (
        .clk    (clk),
        .rst    (rst),
        .nmi_i  (nmi_i),
        .take_i (take_nmi),
        .iret_i (iret_i),
        .pend_o (nmi_pend),
        .mask_o (nmi_mask_o)
    );

    evarb_step_ctl u_step (
        .clk         (clk),
        .rst         (rst),
        .tf_i        (tf_i),
        .sw_take_i   (take_sw),
        .step_take_i (take_step),
        .pend_o      (step_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o <= 1'b0;
            vec_o <= '0;
            src_q <= SRC_NONE;
        end else begin
            ack_o <= grant;
            src_q <= grant ? pick.src : SRC_NONE;
            if (grant)
                vec_o <= pick.vec;
        end
    end

    AST_ACK_NEEDS_BND: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(bnd_i));                                 // R2
    AST_BND_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (bnd_i && (sw_req_i || tf_i || fpu_err_i)) |=> ack_o);   // R2
    AST_STEP_OVER_EXT: assert property (@(posedge clk) disable iff (rst)
        (bnd_i && tf_i && !sw_req_i) |=> (ack_o && vec_o == STEP_VEC)); // R3
    AST_FPU_FIXED_VEC: assert property (@(posedge clk) disable iff (rst)
        (bnd_i && fpu_err_i && !sw_req_i && !tf_i && !step_pend && !nmi_ready)
        |=> (ack_o && vec_o == FPU_VEC));                        // R7
    AST_INTR_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        (src_q == SRC_INTR) |-> $past(ie_i && intr_i));          // R8

endmodule

// File: tb/tb_event_arbiter.sv
module tb_event_arbiter;

    logic       clk = 1'b0;
    logic       rst;
    logic       bnd_i, iret_i, tf_i, ie_i, sw_req_i, nmi_i, fpu_err_i, intr_i;
    logic [7:0] sw_vec_i, intr_vec_i;
    logic       ack_o;
    logic [7:0] vec_o;
    logic       nmi_mask_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam int SWV = 8'h0D;
    localparam int IRV = 8'h48;

    always #2 clk = ~clk;

    event_arbiter dut (
        .clk(clk), .rst(rst), .bnd_i(bnd_i), .iret_i(iret_i), .tf_i(tf_i),
        .ie_i(ie_i), .sw_req_i(sw_req_i), .sw_vec_i(sw_vec_i), .nmi_i(nmi_i),
        .fpu_err_i(fpu_err_i), .intr_i(intr_i), .intr_vec_i(intr_vec_i),
        .ack_o(ack_o), .vec_o(vec_o), .nmi_mask_o(nmi_mask_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        bnd_i = 0; iret_i = 0; tf_i = 0; ie_i = 0; sw_req_i = 0;
        nmi_i = 0; fpu_err_i = 0; intr_i = 0;
        sw_vec_i = 8'(SWV); intr_vec_i = 8'(IRV);
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_in();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    // Boundary on the next rising edge; returns at the falling edge after it.
    task automatic boundary();
        bnd_i = 1;
        @(negedge clk);
        bnd_i = 0;
    endtask

    task automatic nmi_pulse();
        nmi_i = 1;
        @(negedge clk);
        nmi_i = 0;
        @(negedge clk);
    endtask

    // Expected winner of one boundary: -1 means no acknowledge.
    function automatic int expect_vec(bit sw, bit st, bit nm, bit fp, bit it, bit ie);
        if (sw) return SWV;
        if (st) return 1;
        if (nm) return 2;
        if (fp) return 16;
        if (it && ie) return IRV;
        return -1;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst = 1;
        do_reset();
        // R1 reset state
        check("R1 ack", int'(ack_o), 0);
        check("R1 vec", int'(vec_o), 0);
        check("R1 mask", int'(nmi_mask_o), 0);
        boundary();
        check("R1 nothing pending", int'(ack_o), 0);

        // R2 no boundary, no acknowledge
        fpu_err_i = 1; intr_i = 1; ie_i = 1; tf_i = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R2 no bnd", int'(ack_o), 0);
        end
        tf_i = 0;

        // R9/R7/R8 level requests persist after losing
        boundary();
        check("R7 fpu ack", int'(ack_o), 1);
        check("R7 fpu vec", int'(vec_o), 16);
        fpu_err_i = 0;
        @(negedge clk);
        check("R2 single pulse", int'(ack_o), 0);
        boundary();
        check("R9 intr kept", int'(ack_o), 1);
        check("R8 intr vec", int'(vec_o), IRV);
        ie_i = 0;
        boundary();
        check("R8 ie low blocks", int'(ack_o), 0);
        intr_i = 0;

        // R5/R6/R10 NMI masking sequence
        do_reset();
        nmi_pulse();
        boundary();
        check("R5 nmi taken", int'(vec_o), 2);
        check("R6 mask set", int'(nmi_mask_o), 1);
        boundary();
        check("R10 nmi once", int'(ack_o), 0);
        nmi_pulse();
        boundary();
        check("R6 masked nmi held", int'(ack_o), 0);
        intr_i = 1; ie_i = 1;
        boundary();
        check("R6 intr passes mask", int'(vec_o), IRV);
        intr_i = 0;
        iret_i = 1;
        boundary();
        iret_i = 0;
        check("R6 not on iret edge", int'(ack_o), 0);
        check("R6 mask cleared", int'(nmi_mask_o), 0);
        boundary();
        check("R6 nmi after iret ack", int'(ack_o), 1);
        check("R6 nmi after iret vec", int'(vec_o), 2);
        check("R6 mask again", int'(nmi_mask_o), 1);

        // R3/R4/R9 sweep of all request combinations
        for (int c = 0; c < 64; c++) begin
            bit sw, tf, nm, fp, it, ie;
            int e1, e2;
            sw = c[0]; tf = c[1]; nm = c[2]; fp = c[3]; it = c[4]; ie = c[5];
            do_reset();
            if (nm) nmi_pulse();
            sw_req_i = sw; tf_i = tf; fpu_err_i = fp; intr_i = it; ie_i = ie;
            boundary();
            clear_in();
            e1 = expect_vec(sw, tf, nm, fp, it, ie);
            check($sformatf("R3 ack c=%0d", c), int'(ack_o), (e1 >= 0) ? 1 : 0);
            if (e1 >= 0) check($sformatf("R3 vec c=%0d", c), int'(vec_o), e1);
            check($sformatf("R6 mask c=%0d", c), int'(nmi_mask_o), (e1 == 2) ? 1 : 0);
            boundary();
            e2 = expect_vec(0, sw && tf, nm && (e1 != 2), 0, 0, 0);
            check($sformatf("R4 R9 follow ack c=%0d", c), int'(ack_o), (e2 >= 0) ? 1 : 0);
            if (e2 >= 0) check($sformatf("R4 R9 follow vec c=%0d", c), int'(vec_o), e2);
        end

        // R4 pending step beats external requests with trap flag low
        do_reset();
        sw_req_i = 1; tf_i = 1;
        boundary();
        sw_req_i = 0; tf_i = 0; fpu_err_i = 1; intr_i = 1; ie_i = 1;
        boundary();
        check("R4 step first", int'(vec_o), 1);
        boundary();
        check("R4 then fpu", int'(vec_o), 16);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule